// File: doc/BRIEF.md
# Interlocked Multiplexed-Bus Read Master

This block starts read transfers on a shared bus that has no bus clock. The same lines carry the address and then the data. Every step of a transfer waits for the other party to respond, using a four-phase request/acknowledge exchange.

A transfer begins with a one-cycle local request that carries a start address and a word count. The block then:

1. Asks an external arbiter for the bus and waits for the grant.
2. Puts the address on the shared lines and raises its Read strobe.
3. Waits for the slave to acknowledge the address.
4. Collects the words one at a time. For each word it waits for the slave's data-ready signal, captures the lines, hands the word to the local side with a one-cycle valid pulse, and acknowledges it. The address is not sent again between words.
5. Drops its bus request once the last word's exchange has completed.

All three inputs from the bus side are resynchronised with two flip-flops before the controller uses them.

Top module: `abm_master`

## Requirements
- R1: An accepted request raises `bus_req` and `busy` on the next clock edge. `ad_oe`, `rd_strobe` and `mst_ack` stay low until the grant has been seen. Once `bus_gnt` has risen, `ad_oe` rises on the third rising clock edge.
- R2: The address is driven on `ad_out` with `ad_oe` high for at least one cycle before `rd_strobe` rises. The value driven is the `req_addr` captured at acceptance.
- R3: `rd_strobe` and `ad_oe` stay high until the slave acknowledge has been seen. They then fall on the same edge. No data is accepted until the slave acknowledge has been seen low again.
- R4: `ad_oe` is low for the whole data phase, and never high while `mst_ack` is high.
- R5: Each word is handled as follows when data-ready is seen high:
  - `ad_in` is captured onto `rx_data`.
  - `rx_valid` pulses high for exactly one cycle.
  - `mst_ack` rises on that same edge and stays high until data-ready has been seen low.
- R6: Exactly `req_count` words are delivered per transfer. `rd_strobe` rises exactly once per transfer. The remaining-word counter never decrements below zero.
- R7: `bus_req` stays high between words. It falls on the same edge as the final `mst_ack` fall, and never while `mst_ack` is high.
- R8: `slv_ack`, `data_rdy` and `bus_gnt` each pass through a two-flop synchronizer. As a result, `mst_ack` rises on the third rising clock edge after `data_rdy` rises.
- R9: A request with `req_count` equal to zero is not accepted. `bus_req` and `busy` stay low.
- R10: `busy` equals `bus_req` at all times. A `req_valid` pulse seen while busy has no effect: it does not change the address, the word count, or what happens after the current transfer.
- R11: While `rst` is high, `bus_req`, `busy`, `ad_oe`, `rd_strobe`, `mst_ack` and `rx_valid` are all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | One-cycle local start pulse |
| req_addr | input | ADW | Address for the transfer |
| req_count | input | CW | Number of words to read (zero is rejected) |
| busy | output | 1 | High from acceptance until the bus request falls |
| rx_valid | output | 1 | One-cycle strobe for a received word |
| rx_data | output | ADW | Received word |
| bus_req | output | 1 | Bus request to the arbiter |
| bus_gnt | input | 1 | Grant from the arbiter |
| ad_oe | output | 1 | Enable for the tri-state driver of the shared lines |
| ad_out | output | ADW | Address value for the shared lines (zero when not driving) |
| ad_in | input | ADW | Value currently on the shared lines |
| rd_strobe | output | 1 | Read strobe |
| slv_ack | input | 1 | Slave acknowledge |
| data_rdy | input | 1 | Slave data-ready |
| mst_ack | output | 1 | Master acknowledge for each word |

## Verification
The assertions rely on several properties of the bus-side inputs:
- The grant is held for as long as `bus_req` stays high.
- The slave changes `slv_ack` and `data_rdy` only in reply to the master's previous edge.
- The shared lines hold steady while data-ready is high.
- `bus_gnt` has settled low before the next transfer starts.

The bench's arbiter and slave model keep to these rules. All of their drives happen on rising edges. They wait a varied number of cycles before each response, and they hold the grant until the request drops. After each transfer the bench leaves several idle cycles so that the synchronised grant has cleared.

// File: rtl/abm_pkg.sv
package abm_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARB,
        ST_ADDR,
        ST_READ,
        ST_AREL,
        ST_DWAIT,
        ST_DACK
    } abm_state_e;

    typedef struct packed {
        logic bus_req;
        logic ad_oe;
        logic rd;
        logic mack;
    } abm_drive_t;

    function automatic abm_drive_t drive_of(abm_state_e s);
        abm_drive_t d;
        d.bus_req = (s != ST_IDLE);
        d.ad_oe   = (s == ST_ADDR) || (s == ST_READ);
        d.rd      = (s == ST_READ);
        d.mack    = (s == ST_DACK);
        return d;
    endfunction

endpackage

// File: rtl/abm_sync.sv
module abm_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
        end else begin
            chain[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                chain[i] <= chain[i-1];
            end
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/abm_wcount.sv
module abm_wcount #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          dec,
    output logic          zero
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (dec) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign zero = (cnt == '0);

    // R6: a word is never taken with no words remaining
    a_r6_no_underflow: assert property (@(posedge clk) disable iff (rst)
        dec |-> (cnt != '0));
endmodule

// File: rtl/abm_ctrl.sv
module abm_ctrl
    import abm_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       gnt_s,
    input  logic       ack_s,
    input  logic       rdy_s,
    input  logic       cnt_zero,
    output abm_state_e st,
    output logic       load,
    output logic       dec
);
    abm_state_e nxt;

    always_comb begin
        nxt = st;
        unique case (st)
            ST_IDLE:  if (start)  nxt = ST_ARB;
            ST_ARB:   if (gnt_s)  nxt = ST_ADDR;
            ST_ADDR:              nxt = ST_READ;
            ST_READ:  if (ack_s)  nxt = ST_AREL;
            ST_AREL:  if (!ack_s) nxt = ST_DWAIT;
            ST_DWAIT: if (rdy_s)  nxt = ST_DACK;
            ST_DACK:  if (!rdy_s) nxt = cnt_zero ? ST_IDLE : ST_DWAIT;
            default:              nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st <= ST_IDLE;
        else     st <= nxt;
    end

    assign load = (st == ST_IDLE) && start;
    assign dec  = (st == ST_DWAIT) && rdy_s;

    // R6: the address phase is entered only from arbitration
    a_r6_single_addr: assert property (@(posedge clk) disable iff (rst)
        (st == ST_ADDR) |-> $past(st == ST_ARB));
endmodule

// File: rtl/abm_master.sv
module abm_master
    import abm_pkg::*;
#(
    parameter int ADW         = 8,
    parameter int CW          = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           req_valid,
    input  logic [ADW-1:0] req_addr,
    input  logic [CW-1:0]  req_count,
    output logic           busy,
    output logic           rx_valid,
    output logic [ADW-1:0] rx_data,
    output logic           bus_req,
    input  logic           bus_gnt,
    output logic           ad_oe,
    output logic [ADW-1:0] ad_out,
    input  logic [ADW-1:0] ad_in,
    output logic           rd_strobe,
    input  logic           slv_ack,
    input  logic           data_rdy,
    output logic           mst_ack
);
    localparam int NSYNC = 3;

    logic [NSYNC-1:0] raw_in, syn_in;
    logic gnt_s, ack_s, rdy_s;
    logic start, load, dec, cnt_zero;
    logic [ADW-1:0] addr_q;
    abm_state_e st;
    abm_drive_t drv;

    assign raw_in = {bus_gnt, slv_ack, data_rdy};
    assign {gnt_s, ack_s, rdy_s} = syn_in;

    abm_sync #(.W(NSYNC), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .d(raw_in), .q(syn_in)
    );

    assign start = req_valid && (req_count != '0);

    abm_ctrl u_ctrl (
        .clk(clk), .rst(rst), .start(start),
        .gnt_s(gnt_s), .ack_s(ack_s), .rdy_s(rdy_s),
        .cnt_zero(cnt_zero), .st(st), .load(load), .dec(dec)
    );

    abm_wcount #(.CW(CW)) u_cnt (
        .clk(clk), .rst(rst), .load(load), .load_val(req_count),
        .dec(dec), .zero(cnt_zero)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q   <= '0;
            rx_data  <= '0;
            rx_valid <= 1'b0;
        end else begin
            if (load) addr_q <= req_addr;
            rx_valid <= dec;
            if (dec) rx_data <= ad_in;
        end
    end

    assign drv       = drive_of(st);
    assign bus_req   = drv.bus_req;
    assign busy      = drv.bus_req;
    assign ad_oe     = drv.ad_oe;
    assign rd_strobe = drv.rd;
    assign mst_ack   = drv.mack;
    assign ad_out    = drv.ad_oe ? addr_q : '0;

    a_r1_grant_first: assert property (@(posedge clk) disable iff (rst)
        (ad_oe || rd_strobe || mst_ack) |-> gnt_s);

    a_r2_addr_lead: assert property (@(posedge clk) disable iff (rst)
        $rose(rd_strobe) |-> $past(ad_oe));

    a_r3_hold_read: assert property (@(posedge clk) disable iff (rst)
        (rd_strobe && !ack_s) |=> (rd_strobe && ad_oe));

    a_r3_release_together: assert property (@(posedge clk) disable iff (rst)
        $fell(rd_strobe) |-> (!ad_oe && $past(ack_s)));

    a_r4_one_driver: assert property (@(posedge clk) disable iff (rst)
        mst_ack |-> !ad_oe);

    a_r5_hold_ack: assert property (@(posedge clk) disable iff (rst)
        (mst_ack && rdy_s) |=> mst_ack);

    a_r5_latch_with_ack: assert property (@(posedge clk) disable iff (rst)
        $rose(mst_ack) |-> rx_valid);

    a_r7_req_last: assert property (@(posedge clk) disable iff (rst)
        $fell(bus_req) |-> (!mst_ack && !rd_strobe && !ad_oe));
endmodule

// File: tb/sim_abm_master.sv
module sim_abm_master;
    localparam int ADW = 8;
    localparam int CW  = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic           req_valid = 1'b0;
    logic [ADW-1:0] req_addr  = '0;
    logic [CW-1:0]  req_count = '0;
    logic           busy, rx_valid, bus_req, ad_oe, rd_strobe, mst_ack;
    logic [ADW-1:0] rx_data, ad_out;
    logic           bus_gnt  = 1'b0;
    logic [ADW-1:0] ad_in    = '0;
    logic           slv_ack  = 1'b0;
    logic           data_rdy = 1'b0;

    abm_master #(.ADW(ADW), .CW(CW)) u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .req_count(req_count), .busy(busy), .rx_valid(rx_valid),
        .rx_data(rx_data), .bus_req(bus_req), .bus_gnt(bus_gnt),
        .ad_oe(ad_oe), .ad_out(ad_out), .ad_in(ad_in),
        .rd_strobe(rd_strobe), .slv_ack(slv_ack), .data_rdy(data_rdy),
        .mst_ack(mst_ack)
    );

    int checks = 0, fails = 0, cyc = 0;
    int gdelay = 1, gcnt = 0;
    int v_r1 = 0, v_r2 = 0, v_r3 = 0, v_r4 = 0, v_r5 = 0, v_r7 = 0, v_r10 = 0;
    int ack_hi = 0, rdy_lo = 0, rd_rises = 0, rx_n = 0;
    int gnt_cyc = 0, oe_cyc = 0;
    int rx_buf [64];
    logic rd_prev = 0, oe_prev = 0, mack_prev = 0, gnt_prev = 0, rx_prev = 0, breq_prev = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int word_of(int a, int w);
        return (a * 7 + w * 29 + 3) & 255;
    endfunction

    always @(posedge clk) cyc <= cyc + 1;

    // arbiter model: grants after gdelay cycles, holds while requested
    always @(posedge clk) begin
        if (!bus_req) begin
            gcnt    <= 0;
            bus_gnt <= 1'b0;
        end else if (gcnt >= gdelay) begin
            bus_gnt <= 1'b1;
        end else begin
            gcnt <= gcnt + 1;
        end
    end

    // protocol monitor, sampled away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            if (ad_oe && mst_ack) v_r4++;
            if ((ad_oe || rd_strobe || mst_ack) && !bus_gnt) v_r1++;
            if (busy != bus_req) v_r10++;
            if (rd_prev && !rd_strobe && ack_hi < 2) v_r3++;
            if (mack_prev && !mst_ack && rdy_lo < 2) v_r5++;
            if (!rd_prev && rd_strobe) begin
                rd_rises++;
                if (!oe_prev) v_r2++;
            end
            if (bus_gnt && !gnt_prev) gnt_cyc = cyc;
            if (ad_oe && !oe_prev) oe_cyc = cyc;
            if (rx_valid) begin
                if (rx_prev) v_r5++;
                if (rx_n < 64) rx_buf[rx_n] = int'(rx_data);
                rx_n++;
            end
            if (breq_prev && !bus_req && mack_prev == 1'b0 && mst_ack) v_r7++;
            if (bus_req == 1'b0 && mst_ack) v_r7++;
        end
        ack_hi    = slv_ack ? ack_hi + 1 : 0;
        rdy_lo    = data_rdy ? 0 : rdy_lo + 1;
        rd_prev   = rd_strobe;
        oe_prev   = ad_oe;
        mack_prev = mst_ack;
        gnt_prev  = bus_gnt;
        rx_prev   = rx_valid;
        breq_prev = bus_req;
    end

    task automatic do_xfer(input int a, input int n, input bit stray);
        int d, h, lat;
        bit leak;
        d = (a + n) % 3;
        h = n % 3;
        gdelay = n % 4 + 1;
        rx_n = 0;
        rd_rises = 0;
        @(posedge clk);
        req_valid <= 1'b1; req_addr <= ADW'(a); req_count <= CW'(n);
        @(posedge clk);
        req_valid <= 1'b0;
        @(negedge clk);
        chk(busy && bus_req, "R1 busy/bus_req after accept", int'(busy), 1);
        while (!rd_strobe) @(negedge clk);
        chk(ad_oe && int'(ad_out) == a, "R2 address on lines", int'(ad_out), a);
        chk(oe_cyc - gnt_cyc == 3, "R8 grant to address drive", oe_cyc - gnt_cyc, 3);
        if (stray) begin
            @(posedge clk);
            req_valid <= 1'b1; req_addr <= ADW'(a ^ 255); req_count <= CW'(5);
            @(posedge clk);
            req_valid <= 1'b0;
        end
        repeat (d) @(posedge clk);
        @(posedge clk) slv_ack <= 1'b1;
        do @(negedge clk); while (rd_strobe);
        chk(!ad_oe, "R3 driver off with read release", int'(ad_oe), 0);
        repeat (d) @(posedge clk);
        @(posedge clk) slv_ack <= 1'b0;
        for (int w = 0; w < n; w++) begin
            repeat (d) @(posedge clk);
            @(posedge clk);
            ad_in <= ADW'(word_of(a, w));
            data_rdy <= 1'b1;
            lat = 0;
            do begin @(negedge clk); lat++; end while (!mst_ack);
            // rdy rises just after edge P0; ack visible at the negedge after P3
            if (w == 0) chk(lat == 4, "R8 data_rdy to mst_ack", lat, 4);
            chk(!ad_oe, "R4 no address drive in data phase", int'(ad_oe), 0);
            repeat (h) @(posedge clk);
            @(posedge clk);
            data_rdy <= 1'b0;
            ad_in <= '0;
            do @(negedge clk); while (mst_ack);
            if (w == n - 1) chk(!bus_req && !busy, "R7 release after last word", int'(bus_req), 0);
            else            chk(bus_req, "R7 request held between words", int'(bus_req), 1);
        end
        leak = 1'b0;
        repeat (8) begin
            @(negedge clk);
            if (bus_req || busy) leak = 1'b1;
        end
        chk(!leak, "R10 no transfer after stray/ended request", int'(leak), 0);
        chk(rx_n == n, "R6 word count", rx_n, n);
        chk(rd_rises == 1, "R6 single address phase", rd_rises, 1);
        for (int w = 0; w < n && w < 64; w++)
            chk(rx_buf[w] == word_of(a, w), "R5 received word", rx_buf[w], word_of(a, w));
    endtask

    initial begin
        bit seen;
        repeat (3) @(negedge clk);
        chk({bus_req, busy, ad_oe, rd_strobe, mst_ack, rx_valid} == 6'b0,
            "R11 reset outputs", int'({bus_req, busy, ad_oe, rd_strobe, mst_ack, rx_valid}), 0);
        @(posedge clk) rst <= 1'b0;
        repeat (3) @(posedge clk);

        // R9: zero-word request rejected
        @(posedge clk);
        req_valid <= 1'b1; req_addr <= 8'h42; req_count <= '0;
        @(posedge clk) req_valid <= 1'b0;
        seen = 1'b0;
        repeat (6) begin
            @(negedge clk);
            if (bus_req || busy) seen = 1'b1;
        end
        chk(!seen, "R9 zero count ignored", int'(seen), 0);

        foreach (rx_buf[i]) rx_buf[i] = 0;
        for (int ai = 0; ai < 4; ai++) begin
            for (int n = 1; n <= 5; n++) begin
                int a;
                a = (ai == 0) ? 8'h00 : (ai == 1) ? 8'h3C : (ai == 2) ? 8'hA5 : 8'hFF;
                do_xfer(a, n, 1'b0);
            end
        end
        do_xfer(8'h5A, 3, 1'b1);   // R10 stray request while busy
        do_xfer(8'h81, 15, 1'b0);  // R6 largest count

        chk(v_r1 == 0, "R1 bus activity without grant", v_r1, 0);
        chk(v_r2 == 0, "R2 read before address", v_r2, 0);
        chk(v_r3 == 0, "R3 early read release", v_r3, 0);
        chk(v_r4 == 0, "R4 driver overlap", v_r4, 0);
        chk(v_r5 == 0, "R5 ack/valid timing", v_r5, 0);
        chk(v_r7 == 0, "R7 ack without request", v_r7, 0);
        chk(v_r10 == 0, "R10 busy mismatch", v_r10, 0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    always @(posedge clk) begin
        if (cyc == 150000) begin
            checks++;
            fails++;
            $display("FAIL watchdog (all requirements) actual=%0d expected=%0d", cyc, 0);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule